// File: doc/BRIEF.md
# Multi-Channel Conversion Result Buffer

This block sits between an analog-to-digital conversion engine and a processor. The converter hands it one finished sample at a time, as a channel number, a 10-bit result and a one-cycle done strobe. The block keeps the latest sample for every channel, together with two flags per channel. A "fresh" flag says that a sample has arrived and has not yet been read. A sticky "lost" flag says that a sample was replaced before software read it. The block also keeps a shared interrupt-cause flag, which is set by every arrival.

A global latest-sample register runs next to the per-channel buffers. It has its own fresh and lost flags. Software reaches all of this through a simple single-cycle register port. Read data is combinational from the current state. A read of a channel's result register consumes that result. Sticky flags are cleared by writing 0 to their bit, and writing 1 to such a bit does nothing.

Top module: `rbuf_top`

## Requirements
- R1: A store (`cvtValid`=1) writes `cvtData` into the buffer of channel `cvtChan`. A read of address `c` (0..7) returns that buffer in bits [9:0], with 0 in bits [15:10].
- R2: A store sets that channel's fresh flag and the shared interrupt cause `irqCause` on the next clock edge.
- R3: A read of channel address `c` clears only channel `c`'s fresh flag. The status register at address 8 returns the fresh flags in bits [7:0] (bit `c` for channel `c`) and the lost flags in bits [15:8] (bit 8+`c`).
- R4: A store to a channel whose fresh flag is already 1 sets that channel's lost flag. A store to a channel whose fresh flag is 0 leaves the lost flag at 0.
- R5: A lost flag stays set through reads. It clears only on a write to address 8 with 0 in its bit 8+`c`. Writing 1 there, or writing to bits [7:0], has no effect.
- R6: `irqCause` clears only on a write to address 10 with bit 2 = 0. Writing 1 has no effect.
- R7: Every store also updates the global latest register (address 9, bits [9:0]) and sets the global fresh flag (address 10 bit 0). If that flag was already 1, the store also sets the global lost flag (address 10 bit 1). A read of address 9 clears the global fresh flag. Writing 0 to address 10 bit 1 clears the global lost flag. Address 10 bit 2 reads `irqCause`.
- R8: When a read and a store hit the same channel (or address 9 together with any store) in the same cycle, the store wins. The fresh flag stays 1 and no lost flag is set. When a clearing write and a setting store coincide, the flag ends up set.
- R9: Reset clears every buffer and every flag to 0.
- R10: Writes to addresses 0..7 and 9 change nothing. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cvtValid | input | 1 | Converter done strobe |
| cvtChan | input | 3 | Channel of the finished sample |
| cvtData | input | 10 | Finished sample |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational |
| irqCause | output | 1 | Shared conversion-complete interrupt cause |

## Verification
The hardest situations to reach are the same-cycle collisions. These are a read landing on a channel in the very cycle that channel receives a new sample, and a clearing write meeting a setting store. A random stream rarely lines them up on the same channel. Directed cycles therefore force each collision explicitly. A long random phase with heavy traffic on few channels then repeatedly drives fresh flags into the overwrite state, while random reads and clearing writes are compared against a bench model every cycle.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
  parameter int CHAN_W = 3;
  parameter int DATA_W = 10;
  parameter int BUS_W  = 16;
  parameter int ADDR_W = 4;
  localparam int NCHAN = 1 << CHAN_W;

  typedef struct packed {
    logic [NCHAN-1:0] chStore;
    logic [NCHAN-1:0] chRead;
    logic [NCHAN-1:0] chOvfClr;
    logic             glbStore;
    logic             glbRead;
    logic             glbOvfClr;
    logic             irqClr;
  } rbuf_strobe_t;
endpackage

// File: rtl/rbuf_ctrl.sv
module rbuf_ctrl
  import rbuf_pkg::*;
(
  input  logic              cvtValid,
  input  logic [CHAN_W-1:0] cvtChan,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output rbuf_strobe_t      stb
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NCHAN);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NCHAN + 1);
  localparam logic [ADDR_W-1:0] GSTA_ADDR = ADDR_W'(NCHAN + 2);

  logic rdAcc, wrAcc;
  assign rdAcc = busSel && !busWr;
  assign wrAcc = busSel && busWr;

  for (genvar i = 0; i < NCHAN; i++) begin : g_chan
    assign stb.chStore[i]  = cvtValid && (cvtChan == CHAN_W'(i));
    assign stb.chRead[i]   = rdAcc && (busAddr == ADDR_W'(i));
    assign stb.chOvfClr[i] = wrAcc && (busAddr == STAT_ADDR) && !busWdata[NCHAN + i];
  end

  assign stb.glbStore  = cvtValid;
  assign stb.glbRead   = rdAcc && (busAddr == LAST_ADDR);
  assign stb.glbOvfClr = wrAcc && (busAddr == GSTA_ADDR) && !busWdata[1];
  assign stb.irqClr    = wrAcc && (busAddr == GSTA_ADDR) && !busWdata[2];
endmodule

// File: rtl/rbuf_datapath.sv
module rbuf_datapath
  import rbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rbuf_strobe_t      stb,
  input  logic [DATA_W-1:0] cvtData,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irqCause,
  output logic [NCHAN-1:0]  chDone,
  output logic [NCHAN-1:0]  chOvf,
  output logic              glbDone,
  output logic              glbOvf
);
  logic [DATA_W-1:0] chBuf [NCHAN];
  logic [DATA_W-1:0] glbBuf;

  for (genvar i = 0; i < NCHAN; i++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chBuf[i]  <= '0;
        chDone[i] <= 1'b0;
        chOvf[i]  <= 1'b0;
      end else begin
        if (stb.chStore[i]) chBuf[i] <= cvtData;
        chDone[i] <= stb.chStore[i] || (chDone[i] && !stb.chRead[i]);
        chOvf[i]  <= (chOvf[i] && !stb.chOvfClr[i])
                   || (stb.chStore[i] && chDone[i] && !stb.chRead[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glbBuf   <= '0;
      glbDone  <= 1'b0;
      glbOvf   <= 1'b0;
      irqCause <= 1'b0;
    end else begin
      if (stb.glbStore) glbBuf <= cvtData;
      glbDone  <= stb.glbStore || (glbDone && !stb.glbRead);
      glbOvf   <= (glbOvf && !stb.glbOvfClr)
                || (stb.glbStore && glbDone && !stb.glbRead);
      irqCause <= stb.glbStore || (irqCause && !stb.irqClr);
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr < ADDR_W'(NCHAN)) begin
      busRdata[DATA_W-1:0] = chBuf[busAddr[CHAN_W-1:0]];
    end else if (busAddr == ADDR_W'(NCHAN)) begin
      busRdata[NCHAN-1:0]       = chDone;
      busRdata[2*NCHAN-1:NCHAN] = chOvf;
    end else if (busAddr == ADDR_W'(NCHAN + 1)) begin
      busRdata[DATA_W-1:0] = glbBuf;
    end else if (busAddr == ADDR_W'(NCHAN + 2)) begin
      busRdata[2:0] = {irqCause, glbOvf, glbDone};
    end
  end
endmodule

// File: rtl/rbuf_top.sv
module rbuf_top
  import rbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cvtValid,
  input  logic [CHAN_W-1:0] cvtChan,
  input  logic [DATA_W-1:0] cvtData,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irqCause
);
  rbuf_strobe_t     stb;
  logic [NCHAN-1:0] chDone, chOvf;
  logic             glbDone, glbOvf;

  rbuf_ctrl u_ctrl (
    .cvtValid(cvtValid), .cvtChan(cvtChan), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .stb(stb)
  );

  rbuf_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .cvtData(cvtData), .busAddr(busAddr),
    .busRdata(busRdata), .irqCause(irqCause), .chDone(chDone), .chOvf(chOvf),
    .glbDone(glbDone), .glbOvf(glbOvf)
  );
endmodule

// File: rtl/rbuf_checker.sv
module rbuf_checker
  import rbuf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cvtValid,
  input logic [CHAN_W-1:0] cvtChan,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BUS_W-1:0]  busWdata,
  input logic              irqCause,
  input logic [NCHAN-1:0]  chDone,
  input logic [NCHAN-1:0]  chOvf,
  input logic              glbDone,
  input logic              glbOvf
);
  a_r2_store_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cvtValid |=> chDone[$past(cvtChan)] && irqCause && glbDone);

  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irqCause && !(busSel && busWr && busAddr == ADDR_W'(NCHAN + 2) && !busWdata[2])
    |=> irqCause);

  a_r8_collide_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    cvtValid && busSel && !busWr && busAddr == ADDR_W'(cvtChan)
    |=> chDone[$past(cvtChan)] && chOvf == $past(chOvf));

  a_r7_glb_ovf_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(glbOvf) |-> $past(glbDone) && $past(cvtValid));

  for (genvar i = 0; i < NCHAN; i++) begin : g_chk
    a_r4_ovf_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chOvf[i]) |-> $past(chDone[i]) && $past(cvtValid) && $past(cvtChan) == CHAN_W'(i));

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      chOvf[i] && !(busSel && busWr && busAddr == ADDR_W'(NCHAN) && !busWdata[NCHAN + i])
      |=> chOvf[i]);

    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      busSel && !busWr && busAddr == ADDR_W'(i) && !(cvtValid && cvtChan == CHAN_W'(i))
      |=> !chDone[i]);
  end
endmodule

bind rbuf_top rbuf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cvtValid(cvtValid), .cvtChan(cvtChan),
  .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
  .irqCause(irqCause), .chDone(chDone), .chOvf(chOvf),
  .glbDone(glbDone), .glbOvf(glbOvf)
);

// File: tb/rbuf_top_bench.sv
module rbuf_top_bench;
  logic clk = 0, rst_n = 0;
  logic cvtValid = 0;
  logic [2:0] cvtChan = 0;
  logic [9:0] cvtData = 0;
  logic busSel = 0, busWr = 0;
  logic [3:0] busAddr = 0;
  logic [15:0] busWdata = 0;
  logic [15:0] busRdata;
  logic irqCause;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rbuf_top u_rbuf_top (
    .clk(clk), .rst_n(rst_n), .cvtValid(cvtValid), .cvtChan(cvtChan), .cvtData(cvtData),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqCause(irqCause)
  );

  logic [9:0] mBuf [8];
  logic [7:0] mDone, mOvf;
  logic [9:0] mLast;
  logic mGDone, mGOvf, mIrq;

  function automatic logic [15:0] expRead(input logic [3:0] a);
    if (a < 8)  return {6'd0, mBuf[a[2:0]]};
    if (a == 8) return {mOvf, mDone};
    if (a == 9) return {6'd0, mLast};
    if (a == 10) return {13'd0, mIrq, mGOvf, mGDone};
    return 16'd0;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 8; i++) mBuf[i] = 0;
    mDone = 0; mOvf = 0; mLast = 0; mGDone = 0; mGOvf = 0; mIrq = 0;
  endtask

  // one cycle: drive at negedge, check read data and irq, then update model after posedge
  task automatic cyc(input bit sel, input bit wr, input logic [3:0] a, input logic [15:0] wd,
                     input bit cv, input logic [2:0] ch, input logic [9:0] d, input string tag);
    bit rdCh, rdG;
    @(negedge clk);
    busSel = sel; busWr = wr; busAddr = a; busWdata = wd;
    cvtValid = cv; cvtChan = ch; cvtData = d;
    #1;
    if (sel && !wr) check({tag, " read"}, busRdata, expRead(a));
    check("R6 irqCause", {15'd0, irqCause}, {15'd0, mIrq});
    @(posedge clk);
    rdCh = sel && !wr && a < 8;
    rdG  = sel && !wr && a == 9;
    if (sel && wr && a == 8) mOvf = mOvf & wd[15:8];
    if (sel && wr && a == 10) begin
      if (!wd[1]) mGOvf = 0;
      if (!wd[2]) mIrq = 0;
    end
    if (rdCh) mDone[a[2:0]] = 0;
    if (rdG) mGDone = 0;
    if (cv) begin
      if (mDone[ch] && !(rdCh && a[2:0] == ch)) mOvf[ch] = 1;
      if (rdCh && a[2:0] == ch) mDone[ch] = 1;
      mDone[ch] = 1; mBuf[ch] = d;
      if (mGDone && !rdG) mGOvf = 1;
      mGDone = 1; mLast = d; mIrq = 1;
    end
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, "idle"); endtask
  task automatic rd(input logic [3:0] a, input string tag); cyc(1, 0, a, 0, 0, 0, 0, tag); endtask
  task automatic st(input logic [2:0] ch, input logic [9:0] d); cyc(0, 0, 0, 0, 1, ch, d, "store"); endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    modelReset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9 reset state
    rd(8, "R9 status after reset");
    rd(10, "R9 global after reset");
    rd(3, "R9 buffer after reset");
    // R1 R2 store and read back
    st(3, 10'h2A5);
    rd(8, "R2 fresh flag set");
    rd(10, "R2 R7 irq and global fresh");
    rd(3, "R1 buffer value");
    rd(8, "R3 fresh cleared by read");
    // R4 no overwrite when fresh is 0
    st(3, 10'h111);
    rd(8, "R4 no lost flag");
    // R4 overwrite when still fresh
    st(3, 10'h3FF);
    rd(8, "R4 lost flag set");
    rd(3, "R1 overwritten value");
    rd(8, "R5 lost survives read");
    // R10 writes to buffers ignored
    cyc(1, 1, 3, 16'hFFFF, 0, 0, 0, "R10 write");
    rd(3, "R10 buffer unchanged");
    // R5 write 1 no effect, write 0 clears
    cyc(1, 1, 8, 16'hFF00, 0, 0, 0, "R5 write ones");
    rd(8, "R5 lost kept after writing 1");
    cyc(1, 1, 8, 16'hF7FF, 0, 0, 0, "R5 write zero");
    rd(8, "R5 lost cleared");
    // R7 global
    rd(9, "R7 latest value");
    rd(10, "R7 global lost");
    cyc(1, 1, 10, 16'h0004, 0, 0, 0, "R7 clear glb lost");
    rd(10, "R7 glb lost cleared");
    // R6 irq clear
    cyc(1, 1, 10, 16'h0000, 0, 0, 0, "R6 clear irq");
    rd(10, "R6 irq cleared");
    // R8 read and store same channel
    st(5, 10'h050);
    cyc(1, 0, 5, 0, 1, 5, 10'h055, "R8 collide");
    rd(8, "R8 fresh kept, no lost");
    rd(5, "R8 new value stored");
    // R8 clear and set coincide
    st(6, 10'h061);
    cyc(1, 1, 10, 16'h0000, 1, 6, 10'h062, "R8 clear vs set");
    rd(8, "R8 lost set wins");
    rd(10, "R8 irq set wins");
    rd(12, "R10 unused address");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      bit sel, wr, cv;
      logic [3:0] a;
      logic [15:0] wd;
      r = $urandom_range(0, 99);
      sel = r < 70;
      wr = sel && ($urandom_range(0, 9) < 2);
      a = 4'($urandom_range(0, 11));
      wd = 16'($urandom);
      if (wr && $urandom_range(0, 1) == 1) wd = 16'hFFFF;
      cv = $urandom_range(0, 2) != 0;
      cyc(sel, wr, a, wd, cv, 3'($urandom_range(0, 3)), 10'($urandom), "R1 R3 R4 R7 random");
    end
    // R9 reset again mid-run
    @(negedge clk); rst_n = 0; modelReset();
    @(negedge clk); rst_n = 1;
    rd(8, "R9 status after second reset");
    rd(9, "R9 latest after second reset");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule